// File: doc/BRIEF.md
# Flash Page-Buffer Command Sequencer

This block sits between a processor-side command port and a page-programmable nonvolatile array. Software writes a page through a fixed sequence: it claims the page buffer for one target page, fills words of the buffer one at a time, and then commits the buffer. It can also erase a page or give up a half-filled buffer. The sequencer keeps the target address register and the page buffer, decides whether each command is legal in the present state, and answers every accepted command with a one-cycle `done` strobe carrying a `pass` bit.

Ownership of the buffer is tracked explicitly. While one page holds the buffer, a claim for any other page is refused until the owner commits or aborts. An erase is always allowed when the array is writable, but if a page holds the buffer the erase overwrites the address register and wipes the buffer. The owner then holds a corrupted buffer, and every later fill, commit or claim is refused until an abort releases it. Commits and erases keep the block busy for a fixed, parameterised number of cycles. At the end, one strobe goes to the behavioural array port with the page address and, for a commit, the whole buffer.

The states are IDLE (no owner), OPEN (owner, no word written since the claim), LOADING (owner, at least one word written) and BUSY (commit or erase running). IDLE, OPEN and LOADING go to OPEN on a successful claim and to BUSY on an accepted commit or erase. OPEN and LOADING go to LOADING on a good fill. Any non-busy state goes to IDLE on abort. BUSY goes to IDLE at the end of a commit or of an erase with no owner, and to OPEN (owner kept, buffer marked corrupted) at the end of an erase that hit an owned buffer.

Top module: `flash_pgbuf_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass`, `arr_wr_stb` and `arr_er_stb` are all low and no page owns the buffer.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. Opcodes on `cmd_op` are 1 claim, 2 fill, 3 commit, 4 erase and 5 abort. Any other code is accepted and answered with a fail. A non-busy answer is `done`=1 for one cycle, right after the accepting edge, with `pass` holding the result.
- R3: A claim with no owner passes, latches `cmd_page` as the target and clears every buffer word to zero.
- R4: While a page owns the buffer, a claim for a different page fails and changes nothing. A claim for the same page passes and leaves the buffer as it is.
- R5: A fill with an owner and `cmd_idx` below WORDS writes `cmd_data` into that word and passes. A fill with `cmd_idx` ≥ WORDS fails and leaves the buffer unchanged. A fill with no owner fails.
- R6: A commit with an owner holds `busy` high for exactly BUSY_CYC cycles. The cycle after that, `done`=1, `pass`=1 and `arr_wr_stb`=1 for one cycle. At the same time `arr_page` is the claimed page and `arr_data` holds word i at bits [i*DATA_W +: DATA_W]. Ownership is then released.
- R7: A commit with no owner fails at once and raises no strobe.
- R8: An abort passes from any non-busy state. It releases ownership, clears the buffer and resets the address register. A new claim, fill and commit for another page then succeeds, and words not refilled read as zero.
- R9: An erase holds `busy` for BUSY_CYC cycles, then raises `done`, `pass` and `arr_er_stb` for one cycle with `arr_page` equal to the erased page.
- R10: An erase while a page owns the buffer overwrites the address register and clears the buffer. Afterwards, fills, commits and claims all fail until an abort.
- R11: With `wr_protect` high on the accepting edge, a commit or an erase fails at once, raises no strobe and keeps any ownership.
- R12: A command presented while `busy` is high is ignored. It yields no `done` of its own and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_page | input | ADDR_W | Page for claim or erase |
| cmd_idx | input | IDX_W | Buffer word index for fill |
| cmd_data | input | DATA_W | Word for fill |
| wr_protect | input | 1 | Refuse commits and erases |
| busy | output | 1 | Commit or erase in progress |
| done | output | 1 | Command result valid (one cycle) |
| pass | output | 1 | Result of the command, valid with done |
| arr_wr_stb | output | 1 | Page write strobe to the array |
| arr_er_stb | output | 1 | Page erase strobe to the array |
| arr_page | output | ADDR_W | Page address to the array |
| arr_data | output | WORDS*DATA_W | Page contents to the array |

## Verification
The properties assume that `cmd_op` and `cmd_idx` are known whenever `cmd_valid` is high. They also assume that the host treats a command seen during `busy` as lost and does not count it as answered. The stimulus drives inputs on the falling edge and raises `cmd_valid` for a single cycle per command. It waits for `done` before sending the next command, so every answer belongs to exactly one request. The one exception is a directed case that places a claim in the middle of an erase to show that it is dropped.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_OPEN  = 3'd1,
        OP_LOAD  = 3'd2,
        OP_PROG  = 3'd3,
        OP_ERASE = 3'd4,
        OP_ABORT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPEN,
        ST_LOADING,
        ST_BUSY
    } state_e;

    typedef enum logic [2:0] {
        ACT_IGNORE,
        ACT_FAIL,
        ACT_ACK,
        ACT_OPEN,
        ACT_LOAD,
        ACT_PROG,
        ACT_ERASE,
        ACT_ABORT
    } act_e;

endpackage

// File: rtl/pgseq_cmd_decode.sv
module pgseq_cmd_decode
    import pgseq_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 3,
    parameter int WORDS  = 4
) (
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_page,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic              wr_protect,
    input  logic              busy,
    input  logic              own,
    input  logic              stale,
    input  logic [ADDR_W-1:0] addr_q,
    output act_e              act
);

    logic idx_ok;
    logic usable;

    assign idx_ok = (cmd_idx < IDX_W'(WORDS));
    assign usable = own && !stale;

    always_comb begin
        act = ACT_IGNORE;
        if (cmd_valid && !busy) begin
            case (cmd_op)
                OP_OPEN: begin
                    if (!own)
                        act = ACT_OPEN;
                    else if (!stale && (cmd_page == addr_q))
                        act = ACT_ACK;
                    else
                        act = ACT_FAIL;
                end
                OP_LOAD:  act = (usable && idx_ok) ? ACT_LOAD : ACT_FAIL;
                OP_PROG:  act = (usable && !wr_protect) ? ACT_PROG : ACT_FAIL;
                OP_ERASE: act = wr_protect ? ACT_FAIL : ACT_ERASE;
                OP_ABORT: act = ACT_ABORT;
                default:  act = ACT_FAIL;
            endcase
        end
    end

endmodule

// File: rtl/pgseq_page_buffer.sv
module pgseq_page_buffer #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [SEL_W-1:0]        wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [WORDS*DATA_W-1:0] page_flat
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (clr)
                word_q <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                word_q <= wr_data;
        end

        assign page_flat[g*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/pgseq_busy_timer.sv
module pgseq_busy_timer #(
    parameter int BUSY_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);

    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= CNT_W'(BUSY_CYC - 1);
        end else if (run_q) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run_q && (cnt_q == '0);

endmodule

// File: rtl/flash_pgbuf_seq.sv
module flash_pgbuf_seq
    import pgseq_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int WORDS    = 4,
    parameter int BUSY_CYC = 5,
    parameter int IDX_W    = $clog2(WORDS) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [ADDR_W-1:0]       cmd_page,
    input  logic [IDX_W-1:0]        cmd_idx,
    input  logic [DATA_W-1:0]       cmd_data,
    input  logic                    wr_protect,
    output logic                    busy,
    output logic                    done,
    output logic                    pass,
    output logic                    arr_wr_stb,
    output logic                    arr_er_stb,
    output logic [ADDR_W-1:0]       arr_page,
    output logic [WORDS*DATA_W-1:0] arr_data
);

    localparam int SEL_W = $clog2(WORDS);

    state_e            state_q, state_d;
    logic              own_q, own_d;
    logic              stale_q, stale_d;
    logic              job_erase_q, job_erase_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              done_q, pass_q, wr_stb_q, er_stb_q;

    act_e act;
    logic expire;
    logic buf_clr;
    logic buf_wr;

    assign busy = (state_q == ST_BUSY);

    pgseq_cmd_decode #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .WORDS  (WORDS)
    ) decode_i (
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_page   (cmd_page),
        .cmd_idx    (cmd_idx),
        .wr_protect (wr_protect),
        .busy       (busy),
        .own        (own_q),
        .stale      (stale_q),
        .addr_q     (addr_q),
        .act        (act)
    );

    assign buf_clr = (act == ACT_OPEN) || (act == ACT_ABORT) ||
                     ((act == ACT_ERASE) && own_q);
    assign buf_wr  = (act == ACT_LOAD);

    pgseq_page_buffer #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) buffer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_sel    (cmd_idx[SEL_W-1:0]),
        .wr_data   (cmd_data),
        .page_flat (arr_data)
    );

    pgseq_busy_timer #(
        .BUSY_CYC (BUSY_CYC)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  ((act == ACT_PROG) || (act == ACT_ERASE)),
        .expire (expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            own_q       <= 1'b0;
            stale_q     <= 1'b0;
            job_erase_q <= 1'b0;
            addr_q      <= '0;
        end else begin
            state_q     <= state_d;
            own_q       <= own_d;
            stale_q     <= stale_d;
            job_erase_q <= job_erase_d;
            addr_q      <= addr_d;
        end
    end

    // transitions
    always_comb begin
        state_d     = state_q;
        own_d       = own_q;
        stale_d     = stale_q;
        job_erase_d = job_erase_q;
        addr_d      = addr_q;
        unique case (state_q)
            ST_IDLE, ST_OPEN, ST_LOADING: begin
                case (act)
                    ACT_OPEN: begin
                        state_d = ST_OPEN;
                        own_d   = 1'b1;
                        stale_d = 1'b0;
                        addr_d  = cmd_page;
                    end
                    ACT_LOAD: state_d = ST_LOADING;
                    ACT_PROG: begin
                        state_d     = ST_BUSY;
                        own_d       = 1'b0;
                        job_erase_d = 1'b0;
                    end
                    ACT_ERASE: begin
                        state_d     = ST_BUSY;
                        job_erase_d = 1'b1;
                        addr_d      = cmd_page;
                        if (own_q)
                            stale_d = 1'b1;
                    end
                    ACT_ABORT: begin
                        state_d = ST_IDLE;
                        own_d   = 1'b0;
                        stale_d = 1'b0;
                        addr_d  = '0;
                    end
                    default: ;
                endcase
            end
            ST_BUSY: begin
                if (expire)
                    state_d = own_q ? ST_OPEN : ST_IDLE;
            end
        endcase
    end

    // registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            wr_stb_q <= 1'b0;
            er_stb_q <= 1'b0;
        end else begin
            done_q   <= expire ||
                        (act inside {ACT_FAIL, ACT_ACK, ACT_OPEN, ACT_LOAD, ACT_ABORT});
            pass_q   <= expire ||
                        (act inside {ACT_ACK, ACT_OPEN, ACT_LOAD, ACT_ABORT});
            wr_stb_q <= expire && !job_erase_q;
            er_stb_q <= expire && job_erase_q;
        end
    end

    assign done       = done_q;
    assign pass       = pass_q;
    assign arr_wr_stb = wr_stb_q;
    assign arr_er_stb = er_stb_q;
    assign arr_page   = addr_q;

endmodule

// File: rtl/pgseq_checker.sv
module pgseq_checker #(
    parameter int WORDS    = 4,
    parameter int BUSY_CYC = 5,
    parameter int IDX_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [IDX_W-1:0] cmd_idx,
    input logic             wr_protect,
    input logic             busy,
    input logic             done,
    input logic             pass,
    input logic             arr_wr_stb,
    input logic             arr_er_stb
);

    localparam int BW = $clog2(BUSY_CYC + 2) + 1;

    logic [BW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_run <= '0;
        else if (busy)
            busy_run <= busy_run + 1'b1;
        else
            busy_run <= '0;
    end

    a_r2_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (done || busy));

    a_r5_index_beyond_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 3'd2 && cmd_idx >= IDX_W'(WORDS))
        |=> (done && !pass));

    a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == BW'(BUSY_CYC)));

    a_r6_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    a_r9_strobe_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_stb || arr_er_stb) |-> (done && pass && $past(busy)));

    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr_stb && arr_er_stb));

    a_r11_protect_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && wr_protect && (cmd_op == 3'd3 || cmd_op == 3'd4))
        |=> (done && !pass && !arr_wr_stb && !arr_er_stb));

endmodule

bind flash_pgbuf_seq pgseq_checker #(
    .WORDS    (WORDS),
    .BUSY_CYC (BUSY_CYC),
    .IDX_W    (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_idx    (cmd_idx),
    .wr_protect (wr_protect),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .arr_wr_stb (arr_wr_stb),
    .arr_er_stb (arr_er_stb)
);

// File: tb/flash_pgbuf_seq_tb_top.sv
module flash_pgbuf_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 16;
    localparam int WORDS      = 4;
    localparam int BUSY_CYC   = 5;
    localparam int IDX_W      = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cmd_valid = 1'b0;
    logic [2:0]              cmd_op = '0;
    logic [ADDR_W-1:0]       cmd_page = '0;
    logic [IDX_W-1:0]        cmd_idx = '0;
    logic [DATA_W-1:0]       cmd_data = '0;
    logic                    wr_protect = 1'b0;
    logic                    busy, done, pass, arr_wr_stb, arr_er_stb;
    logic [ADDR_W-1:0]       arr_page;
    logic [WORDS*DATA_W-1:0] arr_data;

    int total = 0;
    int bad   = 0;

    // reference model state
    bit                m_own = 0;
    bit                m_stale = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [DATA_W-1:0] m_buf [WORDS];

    flash_pgbuf_seq #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WORDS (WORDS),
        .BUSY_CYC (BUSY_CYC), .IDX_W (IDX_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_page (cmd_page), .cmd_idx (cmd_idx), .cmd_data (cmd_data),
        .wr_protect (wr_protect), .busy (busy), .done (done), .pass (pass),
        .arr_wr_stb (arr_wr_stb), .arr_er_stb (arr_er_stb),
        .arr_page (arr_page), .arr_data (arr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_model();
        logic [63:0] r = '0;
        for (int i = 0; i < WORDS; i++) r[i*DATA_W +: DATA_W] = m_buf[i];
        return r;
    endfunction

    // expected outcome from the requirements; updates model state
    task automatic predict(input int op, input int page, input int idx,
                           input int data, input bit wp, output bit ep,
                           output int kind, output int epage,
                           output logic [63:0] edata);
        ep = 0; kind = 0; epage = 0; edata = '0;
        case (op)
            1: if (!m_own) begin
                   ep = 1; m_own = 1; m_stale = 0; m_addr = ADDR_W'(page);
                   for (int i = 0; i < WORDS; i++) m_buf[i] = '0;
               end else if (!m_stale && m_addr == ADDR_W'(page)) ep = 1;
            2: if (m_own && !m_stale && idx < WORDS) begin
                   ep = 1; m_buf[idx] = DATA_W'(data);
               end
            3: if (m_own && !m_stale && !wp) begin
                   ep = 1; kind = 1; epage = int'(m_addr); edata = pack_model();
                   m_own = 0;
               end
            4: if (!wp) begin
                   ep = 1; kind = 2; epage = page; m_addr = ADDR_W'(page);
                   if (m_own) begin
                       m_stale = 1;
                       for (int i = 0; i < WORDS; i++) m_buf[i] = '0;
                   end
               end
            5: begin
                   ep = 1; m_own = 0; m_stale = 0; m_addr = '0;
                   for (int i = 0; i < WORDS; i++) m_buf[i] = '0;
               end
            default: ep = 0;
        endcase
    endtask

    task automatic run_cmd(input string tag, input int op, input int page,
                           input int idx, input int data, input bit wp);
        bit ep; int kind; int epage; logic [63:0] edata; int nb;
        predict(op, page, idx, data, wp, ep, kind, epage, edata);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_page = ADDR_W'(page);
        cmd_idx = IDX_W'(idx); cmd_data = DATA_W'(data); wr_protect = wp;
        @(negedge clk);
        cmd_valid = 0; wr_protect = 0;
        nb = 0;
        while (!done && nb < BUSY_CYC + 8) begin
            if (busy) nb++;
            @(negedge clk);
        end
        chk(tag, "done", 64'(done), 64'(1));
        chk(tag, "pass", 64'(pass), 64'(ep));
        chk(tag, "busy cycles", 64'(nb), 64'(kind != 0 ? BUSY_CYC : 0));
        chk(tag, "write strobe", 64'(arr_wr_stb), 64'(kind == 1));
        chk(tag, "erase strobe", 64'(arr_er_stb), 64'(kind == 2));
        if (kind != 0) chk(tag, "array page", 64'(arr_page), 64'(epage));
        if (kind == 1) chk(tag, "array data", arr_data, edata);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        int dones;
        seed = $urandom(1234);
        for (int i = 0; i < WORDS; i++) m_buf[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 64'(busy), 0);
        chk("R1", "done", 64'(done), 0);
        chk("R1", "pass", 64'(pass), 0);
        chk("R1", "strobes", 64'({arr_wr_stb, arr_er_stb}), 0);
        rst_n = 1;

        // R3/R5/R6 full page write
        run_cmd("R3", 1, 3, 0, 0, 0);
        for (int i = 0; i < WORDS; i++) run_cmd("R5", 2, 0, i, 16'hA0 + i, 0);
        run_cmd("R5", 2, 0, WORDS, 16'hDEAD, 0);
        run_cmd("R5", 2, 0, WORDS + 1, 16'hBEEF, 0);
        run_cmd("R6", 3, 0, 0, 0, 0);
        // R7 commit without owner
        run_cmd("R7", 3, 0, 0, 0, 0);
        run_cmd("R5", 2, 0, 1, 16'h1111, 0);
        // R4 ownership
        run_cmd("R4", 1, 2, 0, 0, 0);
        run_cmd("R4", 2, 0, 2, 16'h2222, 0);
        run_cmd("R4", 1, 9, 0, 0, 0);
        run_cmd("R4", 1, 2, 0, 0, 0);
        run_cmd("R4", 3, 0, 0, 0, 0);
        // R8 abort then other page
        run_cmd("R8", 1, 1, 0, 0, 0);
        run_cmd("R8", 2, 0, 0, 16'h5555, 0);
        run_cmd("R8", 5, 0, 0, 0, 0);
        run_cmd("R8", 1, 6, 0, 0, 0);
        run_cmd("R8", 2, 0, 1, 16'h6666, 0);
        run_cmd("R8", 3, 0, 0, 0, 0);
        // R9 erase from idle
        run_cmd("R9", 4, 11, 0, 0, 0);
        // R10 erase while owned
        run_cmd("R10", 1, 4, 0, 0, 0);
        run_cmd("R10", 2, 0, 3, 16'h7777, 0);
        run_cmd("R10", 4, 8, 0, 0, 0);
        run_cmd("R10", 2, 0, 0, 16'h8888, 0);
        run_cmd("R10", 3, 0, 0, 0, 0);
        run_cmd("R10", 1, 8, 0, 0, 0);
        run_cmd("R10", 5, 0, 0, 0, 0);
        run_cmd("R10", 1, 4, 0, 0, 0);
        run_cmd("R10", 3, 0, 0, 0, 0);
        // R11 write protect
        run_cmd("R11", 1, 5, 0, 0, 0);
        run_cmd("R11", 2, 0, 2, 16'h9999, 0);
        run_cmd("R11", 3, 0, 0, 0, 1);
        run_cmd("R11", 4, 7, 0, 0, 1);
        run_cmd("R11", 3, 0, 0, 0, 0);
        // R2 undefined opcodes
        run_cmd("R2", 0, 0, 0, 0, 0);
        run_cmd("R2", 6, 0, 0, 0, 0);
        run_cmd("R2", 7, 0, 0, 0, 0);

        // R12 claim during erase is dropped
        begin
            bit ep; int kind; int epage; logic [63:0] edata;
            predict(4, 2, 0, 0, 0, ep, kind, epage, edata);
            @(negedge clk);
            cmd_valid = 1; cmd_op = 3'd4; cmd_page = 4'd2;
            @(negedge clk);
            cmd_valid = 1; cmd_op = 3'd1; cmd_page = 4'd7;
            @(negedge clk);
            cmd_valid = 0;
            dones = 0;
            for (int c = 0; c < BUSY_CYC + 4; c++) begin
                if (done) dones++;
                @(negedge clk);
            end
            chk("R12", "done count", 64'(dones), 64'(1));
        end
        run_cmd("R12", 3, 0, 0, 0, 0);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r, op;
            r = $urandom % 16;
            if (r < 4 || r > 11) op = 2;
            else if (r < 7) op = 1;
            else if (r < 9) op = 3;
            else if (r == 9) op = 4;
            else if (r == 10) op = 5;
            else op = 6 + ($urandom % 2);
            run_cmd("R2", op, $urandom % 4, $urandom % 6, $urandom % 65536,
                    ($urandom % 8) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule